// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

This block is a small 32-bit processor core that completes one instruction in every clock cycle. The core drives the program counter onto an instruction port and decodes the returned word. It reads two source registers from a 32-entry register file and forms either an arithmetic result or a byte address. At the next rising edge it writes the result into a register, or it drives a write to the data port during the cycle. The core knows five operations: register add, register subtract, add-immediate, word load and word store. Any other encoding is retired as a no-op and flagged.

Both memories sit outside the core. Reads from them are combinational: the instruction word for the current PC and the data word for the current address must settle within the same cycle. Writes to data memory take effect at the rising edge while the write strobe is high. The only way to observe register contents is to execute a store and watch the data port.

Top module: `rsc_core`

## Requirements
- R1: The PC is 0 while reset is held and at the first cycle after release, and it grows by 4 at every later rising edge; `imem_addr` always shows the PC.
- R2: Instruction fields sit at fixed positions: opcode [31:26], first source [25:21], second source or load/immediate target [20:16], register-format destination [15:11], function code [5:0], immediate [15:0].
- R3: Opcode 0 with function code 32 writes first source + second source (modulo 2^32) into the destination register.
- R4: Opcode 0 with function code 34 writes first source − second source (modulo 2^32) into the destination register.
- R5: Opcode 8 writes first source + sign-extended immediate into the register named by bits [20:16].
- R6: Opcode 35 drives `dmem_addr` = first source + sign-extended immediate and writes `dmem_rdata` into the register named by bits [20:16]; it raises no data write.
- R7: Opcode 43 raises `dmem_we` for exactly that cycle, with `dmem_addr` = first source + sign-extended immediate and `dmem_wdata` = the register named by bits [20:16]; no register changes.
- R8: Register 0 reads as zero as a source, and any write aimed at it is dropped.
- R9: Any other opcode, or opcode 0 with any function code other than 32 and 34, raises `illegal` during that cycle and changes no register and no memory word; `illegal` is low for the five known operations.
- R10: Reset clears all registers to zero and holds `dmem_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Byte address for a load or a store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe; memory writes at the rising edge |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, combinational |
| illegal | output | 1 | High while the current instruction is not recognised |

## Verification
The assertions assume that both memory ports return the word for the address presented within the same cycle. They also assume that every address the core forms is word aligned and lies inside the attached memory, and that reset starts low. The stimulus meets these conditions in three ways. Every program uses word-multiple offsets against word-aligned bases. Every program starts from a fresh reset. Reset is asserted again as soon as the last instruction retires, so the PC never runs into unloaded words or wraps back onto the program.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned IMM_W  = 16;

  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_ADDI  = 6'd8;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;
  localparam logic [5:0] FN_ADD    = 6'd32;
  localparam logic [5:0] FN_SUB    = 6'd34;

  typedef enum logic [2:0] {
    OPK_ADD,
    OPK_SUB,
    OPK_ADDI,
    OPK_LOAD,
    OPK_STORE,
    OPK_BAD
  } opk_e;

  typedef struct packed {
    opk_e              kind;
    logic [4:0]        src_a;
    logic [4:0]        src_b;
    logic [4:0]        dst;
    logic [WORD_W-1:0] imm;
  } dec_t;

  // widen a 16-bit immediate by copying its top bit
  function automatic logic [WORD_W-1:0] widen_imm(input logic [IMM_W-1:0] raw);
    return {{(WORD_W-IMM_W){raw[IMM_W-1]}}, raw};
  endfunction

  // two's complement add, or subtract when neg is set
  function automatic logic [WORD_W-1:0] addsub(input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] b,
                                               input logic              neg);
    logic [WORD_W-1:0] bb;
    bb = neg ? ~b : b;
    return a + bb + {{(WORD_W-1){1'b0}}, neg};
  endfunction

endpackage

// File: rtl/rsc_decode.sv
module rsc_decode
  import rsc_pkg::*;
(
  input  logic [WORD_W-1:0] insn,
  output dec_t              dec,
  output logic              bad_op
);

  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = insn[31:26];
  assign fn  = insn[5:0];

  always_comb begin
    dec.src_a = insn[25:21];
    dec.src_b = insn[20:16];
    dec.dst   = insn[15:11];
    dec.imm   = widen_imm(insn[15:0]);
    dec.kind  = OPK_BAD;
    case (opc)
      OPC_REG: begin
        if (fn == FN_ADD)      dec.kind = OPK_ADD;
        else if (fn == FN_SUB) dec.kind = OPK_SUB;
        else                   dec.kind = OPK_BAD;
      end
      OPC_ADDI:  dec.kind = OPK_ADDI;
      OPC_LOAD:  dec.kind = OPK_LOAD;
      OPC_STORE: dec.kind = OPK_STORE;
      default:   dec.kind = OPK_BAD;
    endcase
  end

  assign bad_op = (dec.kind == OPK_BAD);

endmodule

// File: rtl/rsc_regfile.sv
module rsc_regfile #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREG   = 32,
  localparam int unsigned AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [AW-1:0]     rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] regs [NREG];
  logic              wr_commit;

  // entry 0 is never written, so it keeps its reset value of zero
  assign wr_commit = wr_en && (wr_addr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_commit) begin
      regs[wr_addr] <= wr_data;
    end
  end

  assign rd_data_a = regs[rd_addr_a];
  assign rd_data_b = regs[rd_addr_b];

  a_r8_zero_port_a: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == '0) |-> (rd_data_a == '0));

  a_r8_zero_port_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_b == '0) |-> (rd_data_b == '0));

endmodule

// File: rtl/rsc_alu.sv
module rsc_alu
  import rsc_pkg::*;
(
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              do_sub,
  output logic [WORD_W-1:0] result
);

  assign result = addsub(op_a, op_b, do_sub);

endmodule

// File: rtl/rsc_core.sv
module rsc_core
  import rsc_pkg::*;
#(
  parameter int unsigned NREG    = 32,
  parameter int unsigned PC_STEP = 4,
  localparam int unsigned RF_AW  = $clog2(NREG)
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata,
  output logic        illegal
);

  logic [WORD_W-1:0] pc;
  dec_t              dec;
  logic              bad_op;
  logic [WORD_W-1:0] val_a;
  logic [WORD_W-1:0] val_b;
  logic [WORD_W-1:0] alu_b;
  logic [WORD_W-1:0] alu_y;
  logic              alu_sub;
  logic              rf_we;
  logic [RF_AW-1:0]  rf_waddr;
  logic [WORD_W-1:0] rf_wdata;
  logic              is_store;
  logic              is_load;

  // program counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc + WORD_W'(PC_STEP);
  end

  assign imem_addr = pc;

  rsc_decode u_decode (
    .insn   (imem_rdata),
    .dec    (dec),
    .bad_op (bad_op)
  );

  rsc_regfile #(
    .DATA_W (WORD_W),
    .NREG   (NREG)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr_a (dec.src_a[RF_AW-1:0]),
    .rd_data_a (val_a),
    .rd_addr_b (dec.src_b[RF_AW-1:0]),
    .rd_data_b (val_b),
    .wr_en     (rf_we),
    .wr_addr   (rf_waddr),
    .wr_data   (rf_wdata)
  );

  assign alu_sub = (dec.kind == OPK_SUB);
  assign alu_b   = (dec.kind == OPK_ADD || dec.kind == OPK_SUB) ? val_b : dec.imm;

  rsc_alu u_alu (
    .op_a   (val_a),
    .op_b   (alu_b),
    .do_sub (alu_sub),
    .result (alu_y)
  );

  assign is_store = (dec.kind == OPK_STORE);
  assign is_load  = (dec.kind == OPK_LOAD);

  // write-back selection
  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = dec.src_b[RF_AW-1:0];
    rf_wdata = alu_y;
    case (dec.kind)
      OPK_ADD, OPK_SUB: begin
        rf_we    = 1'b1;
        rf_waddr = dec.dst[RF_AW-1:0];
      end
      OPK_ADDI: rf_we = 1'b1;
      OPK_LOAD: begin
        rf_we    = 1'b1;
        rf_wdata = dmem_rdata;
      end
      default: rf_we = 1'b0;
    endcase
  end

  assign dmem_addr  = alu_y;
  assign dmem_wdata = val_b;
  assign dmem_we    = rst_n && is_store;
  assign illegal    = bad_op;

  a_r1_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pc == $past(pc) + 32'd4));

  a_r7_store_no_reg: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> !rf_we);

  a_r7_store_addr: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (dmem_addr == val_a + widen_imm(imem_rdata[15:0])));

  a_r6_load_dest: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |-> (rf_we && !dmem_we && rf_waddr == imem_rdata[20:16] && rf_wdata == dmem_rdata));

  a_r5_addi_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_rdata[31:26] == 6'd8) |-> (rf_we && rf_waddr == imem_rdata[20:16]));

  a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!rf_we && !dmem_we));

endmodule

// File: tb/rsc_core_tb.sv
`timescale 1ns/1ps
module rsc_core_tb;

  localparam logic [31:0] NOP = 32'h0000_0020;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, illegal;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic        ill_log [16];
  int          wcount;
  int          nchecks = 0;
  int          nfail = 0;
  int          pc_bad;
  int          rst_bad;

  always #4 clk = ~clk;

  rsc_core u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata),
    .illegal    (illegal)
  );

  assign imem_rdata = (imem_addr[31:8] == 24'd0) ? imem[imem_addr[7:2]] : NOP;
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (dmem_we) begin
      dmem[dmem_addr[7:2]] = dmem_wdata;
      wcount = wcount + 1;
    end
  end

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin
      imem[i] = NOP;
      dmem[i] = 32'd0;
    end
  endtask

  // runs n instructions from a fresh reset, then holds reset again
  task automatic run_prog(input int n);
    rst_n  = 1'b0;
    pc_bad = 0;
    rst_bad = 0;
    @(negedge clk);
    @(negedge clk);
    if (imem_addr !== 32'd0 || dmem_we !== 1'b0) rst_bad = 1;
    wcount = 0;
    rst_n  = 1'b1;
    for (int i = 0; i < n; i++) begin
      ill_log[i] = illegal;
      if (imem_addr !== 32'(4 * i)) pc_bad++;
      @(negedge clk);
    end
    rst_n = 1'b0;
    check("R10 reset state", 32'(rst_bad), 32'd0);
    check("R1 pc sequence", 32'(pc_bad), 32'd0);
  endtask

  initial begin
    int vals [8];
    int ill_errs;
    vals = '{0, 1, -1, 32767, -32768, 32'h1234, -2, 100};
    clear_mem();

    // R3 R4 R5 sweep over immediate pairs
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        clear_mem();
        imem[0] = enc_i(8, 0, 1, vals[i]);
        imem[1] = enc_i(8, 0, 2, vals[j]);
        imem[2] = enc_r(1, 2, 3, 32);
        imem[3] = enc_r(1, 2, 4, 34);
        imem[4] = enc_i(8, 1, 5, vals[j]);
        imem[5] = enc_i(43, 0, 3, 0);
        imem[6] = enc_i(43, 0, 4, 4);
        imem[7] = enc_i(43, 0, 5, 8);
        run_prog(8);
        check("R3 add", dmem[0], 32'(vals[i] + vals[j]));
        check("R4 sub", dmem[1], 32'(vals[i] - vals[j]));
        check("R5 addi", dmem[2], 32'(vals[i] + vals[j]));
        check("R7 store count", 32'(wcount), 32'd3);
      end
    end

    // R10 registers cleared by reset (state from the last sweep run remains before it)
    imem[0] = enc_i(43, 0, 1, 0);
    imem[1] = enc_i(43, 0, 2, 4);
    imem[2] = enc_i(43, 0, 5, 8);
    dmem[0] = 32'hFFFF_FFFF;
    dmem[1] = 32'hFFFF_FFFF;
    dmem[2] = 32'hFFFF_FFFF;
    run_prog(3);
    check("R10 reg1 zero", dmem[0], 32'd0);
    check("R10 reg2 zero", dmem[1], 32'd0);
    check("R10 reg5 zero", dmem[2], 32'd0);

    // R6 loads, R7 stores with negative offsets, R2 field positions
    clear_mem();
    dmem[10] = 32'hDEAD_BEEF;
    dmem[11] = 32'h0F0F_1234;
    imem[0] = enc_i(8, 0, 1, 44);
    imem[1] = enc_i(35, 1, 2, -4);
    imem[2] = enc_i(35, 1, 3, 0);
    imem[3] = enc_i(43, 0, 2, 100);
    imem[4] = enc_i(43, 1, 3, -16);
    imem[5] = enc_i(8, 3, 4, -1);
    imem[6] = enc_i(43, 1, 4, -44);
    run_prog(7);
    check("R6 load neg offset", dmem[25], 32'hDEAD_BEEF);
    check("R7 store neg offset", dmem[7], 32'h0F0F_1234);
    check("R2 R5 loaded reg plus imm", dmem[0], 32'h0F0F_1233);
    check("R6 loads do not write memory", 32'(wcount), 32'd3);
    ill_errs = 0;
    for (int k = 0; k < 7; k++) if (ill_log[k] !== 1'b0) ill_errs++;
    check("R9 known ops not flagged", 32'(ill_errs), 32'd0);

    // R8 register zero
    clear_mem();
    dmem[0] = 32'hCAFE_F00D;
    dmem[1] = 32'hFFFF_FFFF;
    imem[0] = enc_i(8, 0, 1, 32'h55);
    imem[1] = enc_i(8, 0, 0, 123);
    imem[2] = enc_r(1, 1, 0, 32);
    imem[3] = enc_i(35, 0, 0, 0);
    imem[4] = enc_i(43, 0, 0, 4);
    imem[5] = enc_r(0, 1, 6, 32);
    imem[6] = enc_i(43, 0, 6, 8);
    imem[7] = enc_r(1, 0, 7, 34);
    imem[8] = enc_i(43, 0, 7, 12);
    run_prog(9);
    check("R8 writes to reg0 dropped", dmem[1], 32'd0);
    check("R8 reg0 source in add", dmem[2], 32'h55);
    check("R8 reg0 source in sub", dmem[3], 32'h55);

    // R9 illegal encodings
    clear_mem();
    imem[0] = enc_i(8, 0, 6, 77);
    imem[1] = 32'hFC06_0005;
    imem[2] = enc_r(6, 6, 6, 33);
    imem[3] = enc_i(41, 0, 6, 16);
    imem[4] = enc_r(6, 6, 6, 0);
    imem[5] = enc_i(43, 0, 6, 20);
    run_prog(6);
    check("R9 flag on addi", 32'(ill_log[0]), 32'd0);
    check("R9 flag on op 63", 32'(ill_log[1]), 32'd1);
    check("R9 flag on funct 33", 32'(ill_log[2]), 32'd1);
    check("R9 flag on op 41", 32'(ill_log[3]), 32'd1);
    check("R9 flag on funct 0", 32'(ill_log[4]), 32'd1);
    check("R9 flag on store", 32'(ill_log[5]), 32'd0);
    check("R9 register unchanged", dmem[5], 32'd77);
    check("R9 no memory write", dmem[4], 32'd0);
    check("R9 single write only", 32'(wcount), 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    nchecks++;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

endmodule